// File: doc/BRIEF.md
# Fail-Closed Boot Chain Sequencer

This block steps a chain of trust with a fixed number of stages: a root stage, then a loader, an operating system and an application. The root stage is granted execution straight out of reset without any check. Each later stage is granted only after outside hashing and signature logic reports a positive result for it. The sequencer asks for each check with a one-cycle start pulse and names the stage to be checked. It then waits for a done strobe that carries a pass bit.

A single negative result ends the walk for good. The sequencer enters a halted state that only reset clears. No further checks are requested, and no later stage is ever enabled. When the last stage passes, the sequencer enters a complete state and raises a done flag. Outputs are a cumulative per-stage enable mask, the index of the highest running stage, a count of executed stages, and the halted and complete flags.

Top module: `boot_chain_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `stage_en_o` is 4'b0001, `cur_stage_o` is 0, `exec_cnt_o` is 1, and `halted_o` and `boot_done_o` are 0. Only the root stage runs, and it is never checked.
- R2: In the first cycle after reset release, `vfy_start_o` is high for exactly one cycle and `vfy_stage_o` is 1. Every start is a single-cycle pulse, and `vfy_stage_o` names the stage being checked (1 loader, 2 OS, 3 application).
- R3: After a start, no new start is issued until a done has been seen, however long done takes to arrive.
- R4: A done with pass high sets bit k of `stage_en_o` on the next clock edge, where k is the stage being checked. On the same edge `cur_stage_o` becomes k and `exec_cnt_o` rises by one. If more stages remain, the next start comes in the cycle that follows that edge.
- R5: Stages are checked and enabled strictly in the order 1, 2, 3. A stage is never enabled before all lower stages are enabled.
- R6: A done with pass low halts the sequencer on the next clock edge. `halted_o` becomes 1 and the enable mask does not change. A failed loader check leaves `exec_cnt_o` at 1.
- R7: The halted state is sticky until reset. After it is entered, no start is issued and later done/pass pulses change no output.
- R8: When stage 3 passes, `boot_done_o` becomes 1, `exec_cnt_o` is 4 and `stage_en_o` is 4'b1111. After that no start is issued, and done pulses change no output.
- R9: A done that arrives while no check is outstanding, including the cycle in which start is high, is ignored.
- R10: An enable bit, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vfy_done_i | input | 1 | Check result strobe from the outside engines |
| vfy_pass_i | input | 1 | Check result; valid with vfy_done_i |
| vfy_start_o | output | 1 | One-cycle request to check a stage |
| vfy_stage_o | output | 2 | Stage being checked |
| stage_en_o | output | 4 | Cumulative execution enables, bit 0 = root |
| cur_stage_o | output | 2 | Highest enabled stage |
| exec_cnt_o | output | 3 | Number of executed stages, 1 to 4 |
| halted_o | output | 1 | Sticky fail-closed halt |
| boot_done_o | output | 1 | All stages verified and enabled |

## Verification
The start request is combinational from the sequencer state. It is therefore visible in the same cycle the state machine enters its issue state: the first cycle after reset release, and the cycle after each pass. The enable mask, stage index, count and both flags are registered. They change on the single clock edge that samples the done strobe. The bench drives done and pass on a falling edge and removes them on the next falling edge. It compares every result on that second falling edge, one rising edge after the stimulus. For the ignore cases, it pulses done on such a falling edge and reads the mask, count and flags on the next falling edge.

// File: rtl/boot_chain_pkg.sv
package boot_chain_pkg;
  typedef enum logic [1:0] {
    SEQ_ISSUE = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_HALT  = 2'd2,
    SEQ_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/boot_verify_hs.sv
module boot_verify_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic done_i,
  input  logic pass_i,
  output logic start_o,
  output logic pending_o,
  output logic pass_evt_o,
  output logic fail_evt_o
);
  logic pending_q;

  assign start_o    = issue_i & ~pending_q;
  assign pass_evt_o = pending_q & done_i & pass_i;
  assign fail_evt_o = pending_q & done_i & ~pass_i;
  assign pending_o  = pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pending_q <= 1'b0;
    else if (pending_q && done_i) pending_q <= 1'b0;
    else if (start_o)             pending_q <= 1'b1;
  end

  // sequencer must not request while a check is in flight
  assert_one_outstanding_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q |-> !issue_i);

  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

// File: rtl/boot_chain_fsm.sv
module boot_chain_fsm
  import boot_chain_pkg::*;
#(
  parameter int NumStages = 4,
  localparam int StageW   = $clog2(NumStages)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pass_evt_i,
  input  logic              fail_evt_i,
  output logic              issue_o,
  output logic              grant_o,
  output logic [StageW-1:0] target_o,
  output logic              halted_o,
  output logic              done_o
);
  localparam logic [StageW-1:0] LastIdx = StageW'(NumStages - 1);

  seq_state_e        state_q, state_d;
  logic [StageW-1:0] target_q, target_d;

  always_comb begin
    state_d  = state_q;
    target_d = target_q;
    unique case (state_q)
      SEQ_ISSUE: state_d = SEQ_WAIT;
      SEQ_WAIT: begin
        if (pass_evt_i) begin
          if (target_q == LastIdx) begin
            state_d = SEQ_DONE;
          end else begin
            state_d  = SEQ_ISSUE;
            target_d = target_q + StageW'(1);
          end
        end else if (fail_evt_i) begin
          state_d = SEQ_HALT;
        end
      end
      SEQ_HALT: state_d = SEQ_HALT;
      SEQ_DONE: state_d = SEQ_DONE;
      default:  state_d = SEQ_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_ISSUE;
      target_q <= StageW'(1);
    end else begin
      state_q  <= state_d;
      target_q <= target_d;
    end
  end

  assign issue_o  = (state_q == SEQ_ISSUE);
  assign grant_o  = (state_q == SEQ_WAIT) & pass_evt_i;
  assign target_o = target_q;
  assign halted_o = (state_q == SEQ_HALT);
  assign done_o   = (state_q == SEQ_DONE);

  assert_order_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && target_q != LastIdx) |=> (target_q == $past(target_q) + StageW'(1)));

  assert_halt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_HALT) |=> (state_q == SEQ_HALT) && $stable(target_q));

  assert_target_nonroot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (target_q != '0));
endmodule

// File: rtl/boot_stage_mask.sv
module boot_stage_mask #(
  parameter int NumStages = 4,
  localparam int StageW   = $clog2(NumStages),
  localparam int CntW     = $clog2(NumStages + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 grant_i,
  input  logic [StageW-1:0]    grant_idx_i,
  output logic [NumStages-1:0] en_o,
  output logic [StageW-1:0]    cur_o,
  output logic [CntW-1:0]      cnt_o
);
  logic [NumStages-1:0] en_q;

  for (genvar g = 0; g < NumStages; g++) begin : g_stage
    if (g == 0) begin : g_root
      // root runs unconditionally from reset
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q[g] <= 1'b1;
        else         en_q[g] <= 1'b1;
      end
    end else begin : g_chk
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                    en_q[g] <= 1'b0;
        else if (grant_i && grant_idx_i == StageW'(g)) en_q[g] <= 1'b1;
      end

      assert_en_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_q[g] |=> en_q[g]);

      assert_grant_in_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_i && grant_idx_i == StageW'(g)) |-> en_q[g-1]);
    end
  end

  always_comb begin
    cur_o = '0;
    cnt_o = '0;
    for (int i = 0; i < NumStages; i++) begin
      if (en_q[i]) cur_o = StageW'(i);
      cnt_o = cnt_o + CntW'(en_q[i]);
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/boot_chain_seq.sv
module boot_chain_seq #(
  parameter int NumStages = 4,
  localparam int StageW   = $clog2(NumStages),
  localparam int CntW     = $clog2(NumStages + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vfy_done_i,
  input  logic                 vfy_pass_i,
  output logic                 vfy_start_o,
  output logic [StageW-1:0]    vfy_stage_o,
  output logic [NumStages-1:0] stage_en_o,
  output logic [StageW-1:0]    cur_stage_o,
  output logic [CntW-1:0]      exec_cnt_o,
  output logic                 halted_o,
  output logic                 boot_done_o
);
  logic              issue, grant, pending, pass_evt, fail_evt;
  logic [StageW-1:0] target;

  boot_verify_hs u_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue),
    .done_i     (vfy_done_i),
    .pass_i     (vfy_pass_i),
    .start_o    (vfy_start_o),
    .pending_o  (pending),
    .pass_evt_o (pass_evt),
    .fail_evt_o (fail_evt)
  );

  boot_chain_fsm #(.NumStages(NumStages)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pass_evt_i (pass_evt),
    .fail_evt_i (fail_evt),
    .issue_o    (issue),
    .grant_o    (grant),
    .target_o   (target),
    .halted_o   (halted_o),
    .done_o     (boot_done_o)
  );

  boot_stage_mask #(.NumStages(NumStages)) u_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant),
    .grant_idx_i (target),
    .en_o        (stage_en_o),
    .cur_o       (cur_stage_o),
    .cnt_o       (exec_cnt_o)
  );

  assign vfy_stage_o = target;

  for (genvar g = 1; g < NumStages; g++) begin : g_chk
    assert_exec_after_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stage_en_o[g]) |-> $past(vfy_done_i && vfy_pass_i));
  end

  assert_fail_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && vfy_done_i && !vfy_pass_i) |=> halted_o && $stable(stage_en_o));

  assert_halt_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !vfy_start_o);

  assert_complete_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o |-> !vfy_start_o && !halted_o && (&stage_en_o));

  assert_idle_done_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending && vfy_done_i) |=> $stable(stage_en_o));
endmodule

// File: tb/boot_chain_seq_tb_top.sv
module boot_chain_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done = 1'b0;
  logic       pass = 1'b0;
  logic       start;
  logic [1:0] stage;
  logic [3:0] en;
  logic [1:0] cur;
  logic [2:0] cnt;
  logic       halted;
  logic       bdone;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  boot_chain_seq dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .vfy_done_i  (done),
    .vfy_pass_i  (pass),
    .vfy_start_o (start),
    .vfy_stage_o (stage),
    .stage_en_o  (en),
    .cur_stage_o (cur),
    .exec_cnt_o  (cnt),
    .halted_o    (halted),
    .boot_done_o (bdone)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req, int e_en, int e_cur, int e_cnt, int e_halt, int e_done);
    check(req, "stage_en", int'(en), e_en);
    check(req, "cur_stage", int'(cur), e_cur);
    check(req, "exec_cnt", int'(cnt), e_cnt);
    check(req, "halted", int'(halted), e_halt);
    check(req, "boot_done", int'(bdone), e_done);
  endtask

  // R1 R2: apply reset, release on a falling edge, check reset state and first request
  task automatic do_reset();
    done = 1'b0; pass = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_outs("R1", 1, 0, 1, 0, 0);
    rst_n = 1'b1;
    check_outs("R1", 1, 0, 1, 0, 0);
    check("R2", "start after reset", int'(start), 1);
    check("R2", "stage after reset", int'(stage), 1);
  endtask

  // called on a falling edge where start is due; returns one edge after done
  task automatic verify_stage(int stg, bit ok, int gap);
    check("R2", "start high", int'(start), 1);
    check("R2", "stage id", int'(stage), stg);
    @(negedge clk);
    check("R2", "start single cycle", int'(start), 0);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check("R3", "no start while pending", int'(start), 0);
    end
    done = 1'b1; pass = ok;
    @(negedge clk);
    done = 1'b0; pass = 1'b0;
  endtask

  task automatic poke_idle(string req, int n, int e_en, int e_cur, int e_cnt, int e_halt, int e_done);
    for (int i = 0; i < n; i++) begin
      done = 1'b1; pass = i[0];
      @(negedge clk);
      done = 1'b0; pass = 1'b0;
      check(req, "no start", int'(start), 0);
      check_outs(req, e_en, e_cur, e_cnt, e_halt, e_done);
    end
  endtask

  task automatic test_full_pass();
    do_reset();
    verify_stage(1, 1'b1, 2);
    check_outs("R4", 4'b0011, 1, 2, 0, 0);
    verify_stage(2, 1'b1, 0);
    check_outs("R5", 4'b0111, 2, 3, 0, 0);
    verify_stage(3, 1'b1, 3);
    check_outs("R8", 4'b1111, 3, 4, 0, 1);
    check("R8", "no start after complete", int'(start), 0);
    poke_idle("R8", 3, 4'b1111, 3, 4, 0, 1);
  endtask

  task automatic test_fail(int fstg);
    do_reset();
    for (int s = 1; s < fstg; s++) verify_stage(s, 1'b1, s);
    verify_stage(fstg, 1'b0, 1);
    check_outs("R6", (1 << fstg) - 1, fstg - 1, fstg, 1, 0);
    check("R6", "no start after fail", int'(start), 0);
    poke_idle("R7", 3, (1 << fstg) - 1, fstg - 1, fstg, 1, 0);
    repeat (4) @(negedge clk);
    check("R7", "halt held", int'(halted), 1);
    check("R10", "enables held", int'(en), (1 << fstg) - 1);
  endtask

  task automatic test_spurious_done();
    do_reset();
    done = 1'b1; pass = 1'b1; // same cycle as start: nothing outstanding yet
    @(negedge clk);
    done = 1'b0; pass = 1'b0;
    check_outs("R9", 1, 0, 1, 0, 0);
    check("R9", "start gone", int'(start), 0);
    @(negedge clk);
    check("R3", "still waiting", int'(start), 0);
    done = 1'b1; pass = 1'b1;
    @(negedge clk);
    done = 1'b0; pass = 1'b0;
    check_outs("R4", 4'b0011, 1, 2, 0, 0);
    verify_stage(2, 1'b1, 1);
    check_outs("R4", 4'b0111, 2, 3, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all: act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_full_pass();
    test_fail(1);
    test_fail(2);
    test_fail(3);
    test_spurious_done();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule